// File: doc/BRIEF.md
# Runahead Checkpoint Register File

This block holds the architectural integer state of an in-order core that keeps running past a data-cache miss instead of stalling on it. It keeps two complete register sets, each with its own program counter. The regular set is the committed state. The speculative set is used while the core runs ahead. Every speculative register also carries a validity flag.

A load miss in regular mode copies the whole regular state into the speculative set in a single cycle. The copied state has every flag set except the flag of the missing load's destination. The pipeline then keeps executing from the instruction after the load. Results computed from unknown data are marked unknown. Further misses turn into prefetch requests, stores are blocked, and branches that depend on unknown values are reported so the pipeline can fall through. When the original miss data returns, it is written into the regular set and the core resumes after the load. All speculative work is discarded at that point.

The pipeline drives instruction-level events into the block. In a given cycle, an instruction reads through the two read ports and writes through the one write port in the same cycle.

Top module: `ra_ckpt_regfile`

## Requirements
- R1: After reset the block is in regular mode (`runahead`=0), every register reads zero with its ok flag at 1, `cur_pc` equals RESET_PC, and `pf_vld` and `resume_vld` are 0.
- R2: In regular mode, reads and writes use the regular set and every ok flag is 1. Register index 0 always reads zero with ok=1 in both modes, and writes to index 0 are dropped.
- R3: A `ld_miss` in regular mode has the following effects one cycle later:
  - `runahead`=1.
  - The speculative set equals the regular set.
  - Every ok flag is 1 except the one for `ld_idx`.
  - `cur_pc` = `ld_pc`+4.
  - Any `wr_en` in the miss cycle is discarded.
- R4: In runahead mode, a write updates only the speculative set. The written register's ok flag becomes 0 if `wr_use1` is set and `rs1_ok` is 0, or if `wr_use2` is set and `rs2_ok` is 0. Otherwise it becomes 1.
- R5: A `ld_miss` in runahead mode has the following effects:
  - It clears the ok flag of `ld_idx`.
  - It pulses `pf_vld` for one cycle, one cycle later, with `pf_addr` = `ld_addr`.
  - It does not re-checkpoint: `cur_pc` and the other registers are kept.
- R6: A `fill_vld` in runahead mode has the following effects one cycle later. If it coincides with `ld_miss`, the fill wins.
  - `runahead`=0.
  - The checkpointed load's destination in the regular set holds `fill_data`.
  - Every other regular register holds its value from before the checkpoint.
  - `resume_vld` pulses, and `resume_pc` = `cur_pc` = checkpointed `ld_pc`+4.
- R7: A `fill_vld` in regular mode changes nothing: mode, registers and PC are kept, and `resume_vld` stays 0.
- R8: `st_en` equals `st_req` in regular mode and is 0 in runahead mode.
- R9: `br_unres` is 1 only in runahead mode, when `br_chk` is set and a used operand (`wr_use1`/`wr_use2` selecting rs1/rs2) has ok=0. It changes no state.
- R10: `pc_wr_en` loads `pc_wr_val` into the PC of the current mode, seen on `cur_pc` the next cycle. It is ignored in a cycle that checkpoints or exits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rs1_idx | input | AW | Read port 1 index |
| rs2_idx | input | AW | Read port 2 index |
| rs1_data | output | XLEN | Read port 1 data, current mode's set |
| rs2_data | output | XLEN | Read port 2 data, current mode's set |
| rs1_ok | output | 1 | Read port 1 value is known |
| rs2_ok | output | 1 | Read port 2 value is known |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | AW | Write port index |
| wr_data | input | XLEN | Write port data |
| wr_use1 | input | 1 | Current instruction consumes rs1 |
| wr_use2 | input | 1 | Current instruction consumes rs2 |
| pc_wr_en | input | 1 | Update current mode's PC |
| pc_wr_val | input | XLEN | New PC value |
| cur_pc | output | XLEN | PC of the current mode |
| ld_miss | input | 1 | Load missed in the data cache |
| ld_idx | input | AW | Destination of the missing load |
| ld_pc | input | XLEN | PC of the missing load |
| ld_addr | input | XLEN | Line address of the missing load |
| fill_vld | input | 1 | Original miss data returned |
| fill_data | input | XLEN | Returned load value |
| runahead | output | 1 | 1 while running ahead |
| resume_vld | output | 1 | One-cycle pulse on return to regular mode |
| resume_pc | output | XLEN | Resume PC, valid with resume_vld |
| pf_vld | output | 1 | Prefetch request pulse |
| pf_addr | output | XLEN | Prefetch line address |
| st_req | input | 1 | Instruction is a store |
| st_en | output | 1 | Store may proceed |
| br_chk | input | 1 | Instruction is a branch or register jump |
| br_unres | output | 1 | Branch depends on an unknown operand |

## Verification
The bench sweeps the missing load's destination over every register index, including index 0. For each index it checks that exactly that flag is cleared at checkpoint and that exactly that regular register receives the fill. Each pass also writes from a poisoned source and from a clean source, so that propagation can be told apart from flag leakage between entries. A second miss is added during runahead to separate a prefetch from a re-checkpoint. Reads of the whole register file after the exit show whether any speculative write leaked into the committed state. Fills in regular mode, writes to index 0, and store and branch gating in both modes cover the paths that must have no effect.

// File: rtl/ra_pkg.sv
package ra_pkg;
    typedef enum logic {
        MODE_REG = 1'b0,
        MODE_RUN = 1'b1
    } ra_mode_e;
endpackage

// File: rtl/ra_regbank.sv
// One register set. Entry 0 is hardwired to zero. With HAS_LOAD set the
// whole set can be loaded from ld_src in one cycle (checkpoint copy).
module ra_regbank #(
    parameter int NREG     = 32,
    parameter int XLEN     = 32,
    parameter bit HAS_LOAD = 1'b0,
    localparam int AW      = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [AW-1:0]              widx,
    input  logic [XLEN-1:0]            wdata,
    input  logic                       ld_all,
    input  logic [NREG-1:0][XLEN-1:0]  ld_src,
    output logic [NREG-1:0][XLEN-1:0]  rd_all
);
    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] r;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (HAS_LOAD && ld_all) begin
            s_d.r = ld_src;
        end else if (we) begin
            s_d.r[widx] = wdata;
        end
        s_d.r[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_all = s_q.r;
endmodule

// File: rtl/ra_validbits.sv
// Per-register known/unknown flags of the speculative set.
module ra_validbits #(
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ckpt,
    input  logic [AW-1:0]   ckpt_idx,
    input  logic            run_we,
    input  logic [AW-1:0]   run_widx,
    input  logic            run_wval,
    input  logic            miss_inv,
    input  logic [AW-1:0]   miss_idx,
    output logic [NREG-1:0] vld
);
    typedef struct packed {
        logic [NREG-1:0] v;
    } vbits_t;

    vbits_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ckpt) begin
            s_d.v           = '1;
            s_d.v[ckpt_idx] = 1'b0;
        end else begin
            if (run_we)   s_d.v[run_widx] = run_wval;
            if (miss_inv) s_d.v[miss_idx] = 1'b0;
        end
        s_d.v[0] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign vld = s_q.v;
endmodule

// File: rtl/ra_mode_ctrl.sv
// Mode state, both PCs, saved destination, prefetch and resume pulses.
module ra_mode_ctrl #(
    parameter int              XLEN     = 32,
    parameter int              AW       = 5,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_miss,
    input  logic [AW-1:0]   ld_idx,
    input  logic [XLEN-1:0] ld_pc,
    input  logic [XLEN-1:0] ld_addr,
    input  logic            fill_vld,
    input  logic            pc_wr_en,
    input  logic [XLEN-1:0] pc_wr_val,
    output ra_pkg::ra_mode_e mode,
    output logic [XLEN-1:0] reg_pc,
    output logic [XLEN-1:0] run_pc,
    output logic [AW-1:0]   saved_dst,
    output logic            pf_vld,
    output logic [XLEN-1:0] pf_addr,
    output logic            resume_vld,
    output logic            do_ckpt,
    output logic            do_exit,
    output logic            run_miss
);
    import ra_pkg::*;

    localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

    typedef struct packed {
        ra_mode_e        mode;
        logic [XLEN-1:0] reg_pc;
        logic [XLEN-1:0] run_pc;
        logic [XLEN-1:0] pf_addr;
        logic [AW-1:0]   dst;
        logic            pf_vld;
        logic            resume;
    } ctl_t;

    ctl_t s_d, s_q;

    always_comb begin
        do_ckpt  = (s_q.mode == MODE_REG) && ld_miss;
        do_exit  = (s_q.mode == MODE_RUN) && fill_vld;
        run_miss = (s_q.mode == MODE_RUN) && ld_miss && !fill_vld;

        s_d         = s_q;
        s_d.pf_vld  = run_miss;
        s_d.resume  = do_exit;
        if (run_miss) s_d.pf_addr = ld_addr;

        if (do_ckpt) begin
            s_d.mode   = MODE_RUN;
            s_d.reg_pc = ld_pc;
            s_d.run_pc = ld_pc + PC_STEP;
            s_d.dst    = ld_idx;
        end else if (do_exit) begin
            s_d.mode   = MODE_REG;
            s_d.reg_pc = s_q.reg_pc + PC_STEP;
        end else if (pc_wr_en) begin
            if (s_q.mode == MODE_REG) s_d.reg_pc = pc_wr_val;
            else                      s_d.run_pc = pc_wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.mode   <= MODE_REG;
            s_q.reg_pc <= RESET_PC;
            s_q.run_pc <= RESET_PC;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode       = s_q.mode;
    assign reg_pc     = s_q.reg_pc;
    assign run_pc     = s_q.run_pc;
    assign saved_dst  = s_q.dst;
    assign pf_vld     = s_q.pf_vld;
    assign pf_addr    = s_q.pf_addr;
    assign resume_vld = s_q.resume;
endmodule

// File: rtl/ra_ckpt_regfile.sv
module ra_ckpt_regfile #(
    parameter int              NREG     = 32,
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0,
    localparam int             AW       = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   rs1_idx,
    input  logic [AW-1:0]   rs2_idx,
    output logic [XLEN-1:0] rs1_data,
    output logic [XLEN-1:0] rs2_data,
    output logic            rs1_ok,
    output logic            rs2_ok,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic            wr_use1,
    input  logic            wr_use2,
    input  logic            pc_wr_en,
    input  logic [XLEN-1:0] pc_wr_val,
    output logic [XLEN-1:0] cur_pc,
    input  logic            ld_miss,
    input  logic [AW-1:0]   ld_idx,
    input  logic [XLEN-1:0] ld_pc,
    input  logic [XLEN-1:0] ld_addr,
    input  logic            fill_vld,
    input  logic [XLEN-1:0] fill_data,
    output logic            runahead,
    output logic            resume_vld,
    output logic [XLEN-1:0] resume_pc,
    output logic            pf_vld,
    output logic [XLEN-1:0] pf_addr,
    input  logic            st_req,
    output logic            st_en,
    input  logic            br_chk,
    output logic            br_unres
);
    import ra_pkg::*;

    ra_mode_e                  mode;
    logic [XLEN-1:0]           reg_pc, run_pc;
    logic [AW-1:0]             saved_dst;
    logic                      do_ckpt, do_exit, run_miss;
    logic [NREG-1:0][XLEN-1:0] reg_all, run_all;
    logic [NREG-1:0]           vld;
    logic                      in_run;
    logic                      reg_we, run_we, run_wval;
    logic [AW-1:0]             reg_widx;
    logic [XLEN-1:0]           reg_wdata;
    logic                      bad1, bad2;

    ra_mode_ctrl #(.XLEN(XLEN), .AW(AW), .RESET_PC(RESET_PC)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .ld_miss(ld_miss), .ld_idx(ld_idx), .ld_pc(ld_pc), .ld_addr(ld_addr),
        .fill_vld(fill_vld), .pc_wr_en(pc_wr_en), .pc_wr_val(pc_wr_val),
        .mode(mode), .reg_pc(reg_pc), .run_pc(run_pc), .saved_dst(saved_dst),
        .pf_vld(pf_vld), .pf_addr(pf_addr), .resume_vld(resume_vld),
        .do_ckpt(do_ckpt), .do_exit(do_exit), .run_miss(run_miss)
    );

    assign in_run = (mode == MODE_RUN);

    // Regular set: normal writes in regular mode, fill on exit.
    always_comb begin
        reg_we    = do_exit || (!in_run && wr_en && !ld_miss);
        reg_widx  = do_exit ? saved_dst : wr_idx;
        reg_wdata = do_exit ? fill_data : wr_data;
    end

    ra_regbank #(.NREG(NREG), .XLEN(XLEN), .HAS_LOAD(1'b0)) u_regset (
        .clk(clk), .rst_n(rst_n),
        .we(reg_we), .widx(reg_widx), .wdata(reg_wdata),
        .ld_all(1'b0), .ld_src('0), .rd_all(reg_all)
    );

    // Speculative set: bulk copy at checkpoint, writes while running ahead.
    assign run_we = in_run && wr_en && !ld_miss && !fill_vld;

    ra_regbank #(.NREG(NREG), .XLEN(XLEN), .HAS_LOAD(1'b1)) u_runset (
        .clk(clk), .rst_n(rst_n),
        .we(run_we), .widx(wr_idx), .wdata(wr_data),
        .ld_all(do_ckpt), .ld_src(reg_all), .rd_all(run_all)
    );

    // Operand status and poison propagation.
    always_comb begin
        rs1_data = in_run ? run_all[rs1_idx] : reg_all[rs1_idx];
        rs2_data = in_run ? run_all[rs2_idx] : reg_all[rs2_idx];
        rs1_ok   = !in_run || vld[rs1_idx];
        rs2_ok   = !in_run || vld[rs2_idx];
        bad1     = wr_use1 && !rs1_ok;
        bad2     = wr_use2 && !rs2_ok;
        run_wval = !(bad1 || bad2);
    end

    ra_validbits #(.NREG(NREG)) u_vld (
        .clk(clk), .rst_n(rst_n),
        .ckpt(do_ckpt), .ckpt_idx(ld_idx),
        .run_we(run_we), .run_widx(wr_idx), .run_wval(run_wval),
        .miss_inv(run_miss), .miss_idx(ld_idx),
        .vld(vld)
    );

    assign cur_pc    = in_run ? run_pc : reg_pc;
    assign resume_pc = reg_pc;
    assign runahead  = in_run;
    assign st_en     = st_req && !in_run;
    assign br_unres  = in_run && br_chk && (bad1 || bad2);
endmodule

// File: rtl/ra_ckpt_chk.sv
module ra_ckpt_chk #(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   rs1_idx,
    input logic [XLEN-1:0] rs1_data,
    input logic            rs1_ok,
    input logic            ld_miss,
    input logic [XLEN-1:0] ld_pc,
    input logic [XLEN-1:0] ld_addr,
    input logic            fill_vld,
    input logic            runahead,
    input logic [XLEN-1:0] cur_pc,
    input logic            resume_vld,
    input logic [XLEN-1:0] resume_pc,
    input logic            pf_vld,
    input logic [XLEN-1:0] pf_addr,
    input logic            st_en,
    input logic            br_unres
);
    localparam logic [XLEN-1:0] STEP4 = XLEN'(4);

    // R2
    x0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_idx == '0) |-> (rs1_data == '0 && rs1_ok));

    // R3
    ckpt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!runahead && ld_miss) |=> (runahead && cur_pc == $past(ld_pc) + STEP4));

    // R5
    pf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (runahead && ld_miss && !fill_vld) |=> (pf_vld && pf_addr == $past(ld_addr) && runahead));

    // R6
    exit_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (runahead && fill_vld) |=> (!runahead && resume_vld && resume_pc == cur_pc));

    // R7
    fill_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!runahead && fill_vld && !ld_miss) |=> (!runahead && !resume_vld));

    // R8
    store_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        runahead |-> !st_en);

    // R9
    br_regular_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !runahead |-> !br_unres);
endmodule

bind ra_ckpt_regfile ra_ckpt_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rs1_idx(rs1_idx), .rs1_data(rs1_data),
    .rs1_ok(rs1_ok), .ld_miss(ld_miss), .ld_pc(ld_pc), .ld_addr(ld_addr),
    .fill_vld(fill_vld), .runahead(runahead), .cur_pc(cur_pc),
    .resume_vld(resume_vld), .resume_pc(resume_pc), .pf_vld(pf_vld),
    .pf_addr(pf_addr), .st_en(st_en), .br_unres(br_unres)
);

// File: tb/sim_ra_ckpt_regfile.sv
module sim_ra_ckpt_regfile;
    localparam int NR = 8;
    localparam int XW = 16;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] rs1_idx = '0, rs2_idx = '0, wr_idx = '0, ld_idx = '0;
    logic [XW-1:0] rs1_data, rs2_data, cur_pc, resume_pc, pf_addr;
    logic          rs1_ok, rs2_ok, runahead, resume_vld, pf_vld, st_en, br_unres;
    logic          wr_en = 0, wr_use1 = 0, wr_use2 = 0, pc_wr_en = 0;
    logic          ld_miss = 0, fill_vld = 0, st_req = 0, br_chk = 0;
    logic [XW-1:0] wr_data = '0, pc_wr_val = '0, ld_pc = '0, ld_addr = '0, fill_data = '0;

    always #5 clk = ~clk;

    ra_ckpt_regfile #(.NREG(NR), .XLEN(XW), .RESET_PC(16'h0)) u0 (
        .clk(clk), .rst_n(rst_n), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
        .rs1_data(rs1_data), .rs2_data(rs2_data), .rs1_ok(rs1_ok), .rs2_ok(rs2_ok),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_use1(wr_use1),
        .wr_use2(wr_use2), .pc_wr_en(pc_wr_en), .pc_wr_val(pc_wr_val),
        .cur_pc(cur_pc), .ld_miss(ld_miss), .ld_idx(ld_idx), .ld_pc(ld_pc),
        .ld_addr(ld_addr), .fill_vld(fill_vld), .fill_data(fill_data),
        .runahead(runahead), .resume_vld(resume_vld), .resume_pc(resume_pc),
        .pf_vld(pf_vld), .pf_addr(pf_addr), .st_req(st_req), .st_en(st_en),
        .br_chk(br_chk), .br_unres(br_unres)
    );

    int errs = 0;
    int nchk = 0;
    logic [XW-1:0] mreg [NR];
    logic [XW-1:0] mra  [NR];
    logic          mv   [NR];
    logic          mmode = 0;
    logic [XW-1:0] mregpc = '0, mrunpc = '0;
    logic [AW-1:0] mdst = '0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic bit okm(input int i);
        return !mmode || i == 0 || mv[i];
    endfunction

    task automatic chk_all(input string rq);
        for (int i = 0; i < NR; i++) begin
            int j;
            logic [XW-1:0] e1, e2;
            j = NR - 1 - i;
            @(negedge clk);
            rs1_idx = AW'(i);
            rs2_idx = AW'(j);
            #1;
            e1 = mmode ? mra[i] : mreg[i];
            e2 = mmode ? mra[j] : mreg[j];
            chk(rs1_data == e1, rq, 32'(rs1_data), 32'(e1));
            chk(rs2_data == e2, rq, 32'(rs2_data), 32'(e2));
            chk(rs1_ok == okm(i), rq, 32'(rs1_ok), 32'(okm(i)));
            chk(rs2_ok == okm(j), rq, 32'(rs2_ok), 32'(okm(j)));
        end
        chk(runahead == mmode, rq, 32'(runahead), 32'(mmode));
        chk(cur_pc == (mmode ? mrunpc : mregpc), rq, 32'(cur_pc), 32'(mmode ? mrunpc : mregpc));
    endtask

    task automatic op_wr(input int idx, input logic [XW-1:0] d, input int s1, input int s2,
                         input bit u1, input bit u2);
        bit v;
        @(negedge clk);
        rs1_idx = AW'(s1); rs2_idx = AW'(s2);
        wr_idx = AW'(idx); wr_data = d; wr_use1 = u1; wr_use2 = u2; wr_en = 1;
        v = !(u1 && !okm(s1)) && !(u2 && !okm(s2));
        @(posedge clk); #1;
        wr_en = 0; wr_use1 = 0; wr_use2 = 0;
        if (idx != 0) begin
            if (mmode) begin mra[idx] = d; mv[idx] = v; end
            else       mreg[idx] = d;
        end
    endtask

    task automatic op_miss(input int idx, input logic [XW-1:0] pc, input logic [XW-1:0] addr);
        @(negedge clk);
        ld_miss = 1; ld_idx = AW'(idx); ld_pc = pc; ld_addr = addr;
        @(posedge clk); #1;
        ld_miss = 0;
        if (!mmode) begin
            for (int i = 0; i < NR; i++) begin mra[i] = mreg[i]; mv[i] = 1'b1; end
            if (idx != 0) mv[idx] = 1'b0;
            mmode = 1; mregpc = pc; mrunpc = pc + 16'd4; mdst = AW'(idx);
            chk(runahead == 1'b1, "R3", 32'(runahead), 1);
            chk(cur_pc == mrunpc, "R3", 32'(cur_pc), 32'(mrunpc));
            chk(pf_vld == 1'b0, "R3", 32'(pf_vld), 0);
        end else begin
            if (idx != 0) mv[idx] = 1'b0;
            chk(pf_vld == 1'b1, "R5", 32'(pf_vld), 1);
            chk(pf_addr == addr, "R5", 32'(pf_addr), 32'(addr));
            chk(runahead == 1'b1, "R5", 32'(runahead), 1);
            chk(cur_pc == mrunpc, "R5", 32'(cur_pc), 32'(mrunpc));
        end
    endtask

    task automatic op_fill(input logic [XW-1:0] d);
        bit was_run;
        was_run = mmode;
        @(negedge clk);
        fill_vld = 1; fill_data = d;
        @(posedge clk); #1;
        fill_vld = 0;
        if (was_run) begin
            if (mdst != 0) mreg[mdst] = d;
            mmode = 0; mregpc = mregpc + 16'd4;
            chk(runahead == 1'b0, "R6", 32'(runahead), 0);
            chk(resume_vld == 1'b1, "R6", 32'(resume_vld), 1);
            chk(resume_pc == mregpc, "R6", 32'(resume_pc), 32'(mregpc));
            chk(cur_pc == mregpc, "R6", 32'(cur_pc), 32'(mregpc));
        end else begin
            chk(resume_vld == 1'b0, "R7", 32'(resume_vld), 0);
            chk(runahead == 1'b0, "R7", 32'(runahead), 0);
            chk(cur_pc == mregpc, "R7", 32'(cur_pc), 32'(mregpc));
        end
    endtask

    task automatic op_pc(input logic [XW-1:0] v);
        @(negedge clk);
        pc_wr_en = 1; pc_wr_val = v;
        @(posedge clk); #1;
        pc_wr_en = 0;
        if (mmode) mrunpc = v; else mregpc = v;
        chk(cur_pc == v, "R10", 32'(cur_pc), 32'(v));
    endtask

    task automatic gate_chk(input int src);
        bit e_br;
        e_br = mmode && !okm(src);
        @(negedge clk);
        st_req = 1; br_chk = 1; rs1_idx = AW'(src); wr_use1 = 1;
        #1;
        chk(st_en == !mmode, "R8", 32'(st_en), 32'(!mmode));
        chk(br_unres == e_br, "R9", 32'(br_unres), 32'(e_br));
        @(posedge clk); #1;
        st_req = 0; br_chk = 0; wr_use1 = 0;
    endtask

    initial begin
        #1000000;
        errs++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, nchk + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) begin mreg[i] = '0; mra[i] = '0; mv[i] = 1'b1; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk(runahead == 1'b0, "R1", 32'(runahead), 0);
        chk(cur_pc == 16'h0, "R1", 32'(cur_pc), 0);
        chk(pf_vld == 1'b0, "R1", 32'(pf_vld), 0);
        chk(resume_vld == 1'b0, "R1", 32'(resume_vld), 0);
        chk_all("R1");

        // R2 index 0 write in regular mode is dropped
        op_wr(0, 16'hFFFF, 0, 0, 0, 0);
        chk_all("R2");
        // R7 fill while regular
        op_fill(16'h1111);
        chk_all("R7");

        for (int d = 0; d < NR; d++) begin
            for (int i = 1; i < NR; i++) op_wr(i, XW'(d * 256 + i * 17 + 1), 0, 0, 0, 0);
            chk_all("R2");
            gate_chk(d);                                   // R8 R9 regular
            op_pc(XW'(16'h200 + d * 16));                  // R10 regular
            op_miss(d, XW'(16'h400 + d * 32), XW'(16'h7000 + d));
            chk_all("R3");
            gate_chk(d);                                   // R8 R9 runahead
            chk_all("R9");
            op_wr((d + 1) % NR, XW'(16'hC000 + d), d, 0, 1, 0);
            op_wr((d + 2) % NR, XW'(16'hD000 + d), (d + 4) % NR, 0, 1, 1);
            chk_all("R4");
            op_miss((d + 3) % NR, XW'(16'h0F00), XW'(16'h8000 + d * 64));
            chk_all("R5");
            op_wr(0, 16'hFFFF, 0, 0, 0, 0);                // R2 in runahead
            op_pc(XW'(16'h600 + d));                       // R10 runahead
            chk_all("R2");
            op_fill(XW'(16'hA000 + d));
            chk_all("R6");
            op_fill(16'h5555);
            chk_all("R7");
        end

        $display("Result: errors=%0d of %0d checks", errs, nchk);
        $finish;
    end
endmodule